// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This block is a purely combinational execution unit for three added register-to-register operations on 32-bit words. A 2-bit operation select, two source register values and a 16-bit immediate come in. Up to two result words go out, each with its own write-enable flag. A destination flag tells the surrounding datapath which register index to use for the first result.

The split operation breaks the first source into its lower and upper halves. Each half is zero-extended and written to its own destination, so this is the only operation that produces two results. The bit-equal operation marks every bit position where the two sources agree. The replace-under-mask operation sign-extends the immediate into a 32-bit mask. It takes masked bits from the first source and unmasked bits from the second, and the result goes back to the second source's register. The block has no clock and no state. Register file access, decoding of full instruction words and pipeline control belong to the surrounding datapath.

Operation codes on `op_sel`: 2'b00 split, 2'b01 bit-equal, 2'b10 replace-under-mask, 2'b11 invalid.

Top module: `bmx_exec`

## Requirements
- R1: With `op_sel` = 2'b00, `res_a` equals `src_a[15:0]` in bits 15:0 with bits 31:16 zero.
- R2: With `op_sel` = 2'b00, `res_b` equals `src_a[31:16]` placed in bits 15:0 (a right shift by 16 with zero fill).
- R3: With `op_sel` = 2'b01, each bit of `res_a` is 1 exactly when the same bit of `src_a` and `src_b` are equal.
- R4: With `op_sel` = 2'b10, the mask is `imm` sign-extended to 32 bits, so `imm[15]` decides all of mask bits 31:16.
- R5: With `op_sel` = 2'b10, a `res_a` bit comes from `src_a` where the mask bit is 1 and from `src_b` where it is 0.
- R6: `dst_is_srcb` is 1 only for `op_sel` = 2'b10; the first result is then meant for the second source's register.
- R7: `res_a_we` is 1 for codes 00, 01 and 10; `res_b_we` is 1 only for code 00.
- R8: With `op_sel` = 2'b11, both write enables and `dst_is_srcb` are 0, and both results are zero.
- R9: For every code other than 00, `res_b` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation select (00 split, 01 bit-equal, 10 replace-under-mask, 11 invalid) |
| src_a | input | XLEN (32) | First source register value |
| src_b | input | XLEN (32) | Second source register value |
| imm | input | IMM_W (16) | Immediate, sign-extended to form the mask |
| res_a | output | XLEN (32) | First result word |
| res_a_we | output | 1 | Write enable for the first result |
| res_b | output | XLEN (32) | Second result word (split only) |
| res_b_we | output | 1 | Write enable for the second result |
| dst_is_srcb | output | 1 | First result goes to the second source's register |

## Verification
The immediate assertions are evaluated whenever the combinational logic settles. They take for granted that every input bit holds a known 0 or 1 and that the inputs stay constant while the outputs are read. The bench drives every input bit to a defined value on one clock edge and reads the outputs half a period later, so no check sees values that are still changing. The bench covers all four select codes, including the invalid one. For the mask, it covers both signs of the immediate and mask values of all ones and all zeros.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

    typedef enum logic [1:0] {
        OP_SPLIT = 2'b00,
        OP_BEQ   = 2'b01,
        OP_RMASK = 2'b10,
        OP_NONE  = 2'b11
    } bmx_op_e;

    typedef struct packed {
        logic we_a;
        logic we_b;
        logic dst_b;
    } bmx_ctl_t;

endpackage

// File: rtl/bmx_decode.sv
module bmx_decode
    import bmx_pkg::*;
(
    input  logic [1:0] op_sel,
    output bmx_op_e    op,
    output bmx_ctl_t   ctl
);

    assign op = bmx_op_e'(op_sel);

    always_comb begin
        ctl = '0;
        unique case (op)
            OP_SPLIT: begin
                ctl.we_a = 1'b1;
                ctl.we_b = 1'b1;
            end
            OP_BEQ: begin
                ctl.we_a = 1'b1;
            end
            OP_RMASK: begin
                ctl.we_a  = 1'b1;
                ctl.dst_b = 1'b1;
            end
            OP_NONE: begin
                ctl = '0;
            end
        endcase
    end

    always_comb begin
        if (ctl.dst_b) begin
            AST_DST_ONLY_MASKOP: assert (op_sel == 2'b10) else $error("destination flag outside replace-under-mask"); // R6
        end
    end

endmodule

// File: rtl/bmx_split.sv
module bmx_split #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] src,
    output logic [XLEN-1:0] lo_word,
    output logic [XLEN-1:0] hi_word
);

    localparam int HALF = XLEN / 2;

    assign lo_word = {{HALF{1'b0}}, src[HALF-1:0]};
    assign hi_word = src >> HALF;

    always_comb begin
        AST_SPLIT_REJOIN: assert ({hi_word[HALF-1:0], lo_word[HALF-1:0]} == src) else $error("split halves do not rebuild the source"); // R2
    end

endmodule

// File: rtl/bmx_biteq.sv
module bmx_biteq #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    output logic [XLEN-1:0] match
);

    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        assign match[i] = (lhs[i] == rhs[i]);
    end

    always_comb begin
        if (lhs == rhs) begin
            AST_EQ_ALL_ONES: assert (&match) else $error("identical sources gave a zero bit"); // R3
        end
    end

endmodule

// File: rtl/bmx_mask.sv
module bmx_mask #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  take_one,
    input  logic [XLEN-1:0]  take_zero,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  merged
);

    localparam int EXT = XLEN - IMM_W;

    logic [XLEN-1:0] mask;

    if (EXT > 0) begin : g_sext
        assign mask = {{EXT{imm[IMM_W-1]}}, imm};
    end else begin : g_flat
        assign mask = imm[XLEN-1:0];
    end

    for (genvar i = 0; i < XLEN; i++) begin : g_sel
        assign merged[i] = mask[i] ? take_one[i] : take_zero[i];
    end

    always_comb begin
        if (imm[IMM_W-1] && EXT > 0) begin
            AST_SEXT_UPPER: assert (merged[XLEN-1:IMM_W] == take_one[XLEN-1:IMM_W]) else $error("negative immediate did not select upper bits from first source"); // R4
        end
        if (imm == '0) begin
            AST_ZERO_MASK: assert (merged == take_zero) else $error("empty mask did not pass second source"); // R5
        end
    end

endmodule

// File: rtl/bmx_exec.sv
module bmx_exec
    import bmx_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [1:0]       op_sel,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  res_a,
    output logic             res_a_we,
    output logic [XLEN-1:0]  res_b,
    output logic             res_b_we,
    output logic             dst_is_srcb
);

    localparam int HALF = XLEN / 2;

    bmx_op_e         op;
    bmx_ctl_t        ctl;
    logic [XLEN-1:0] split_lo;
    logic [XLEN-1:0] split_hi;
    logic [XLEN-1:0] eq_word;
    logic [XLEN-1:0] mask_word;

    bmx_decode u_decode (
        .op_sel (op_sel),
        .op     (op),
        .ctl    (ctl)
    );

    bmx_split #(.XLEN(XLEN)) u_split (
        .src     (src_a),
        .lo_word (split_lo),
        .hi_word (split_hi)
    );

    bmx_biteq #(.XLEN(XLEN)) u_biteq (
        .lhs   (src_a),
        .rhs   (src_b),
        .match (eq_word)
    );

    bmx_mask #(.XLEN(XLEN), .IMM_W(IMM_W)) u_mask (
        .take_one  (src_a),
        .take_zero (src_b),
        .imm       (imm),
        .merged    (mask_word)
    );

    always_comb begin
        res_a = '0;
        res_b = '0;
        unique case (op)
            OP_SPLIT: begin
                res_a = split_lo;
                res_b = split_hi;
            end
            OP_BEQ:   res_a = eq_word;
            OP_RMASK: res_a = mask_word;
            OP_NONE:  res_a = '0;
        endcase
    end

    assign res_a_we    = ctl.we_a;
    assign res_b_we    = ctl.we_b;
    assign dst_is_srcb = ctl.dst_b;

    always_comb begin
        if (res_b_we) begin
            AST_SECOND_NEEDS_FIRST: assert (res_a_we) else $error("second enable without first"); // R7
            AST_SPLIT_UPPER_ZERO: assert (res_a[XLEN-1:HALF] == '0 && res_b[XLEN-1:HALF] == '0) else $error("split result upper half not zero"); // R1
        end
        if (op_sel == 2'b11) begin
            AST_INVALID_QUIET: assert (!res_a_we && !res_b_we && !dst_is_srcb && res_a == '0 && res_b == '0) else $error("invalid code had an effect"); // R8
        end
        if (!res_b_we) begin
            AST_SECOND_IDLE_ZERO: assert (res_b == '0) else $error("second result nonzero without its enable"); // R9
        end
    end

endmodule

// File: tb/bmx_exec_tb.sv
module bmx_exec_tb;

    localparam int  CLK_PERIOD = 10;
    localparam int  XLEN       = 32;
    localparam int  IMM_W      = 16;
    localparam int  WATCHDOG   = 5000;

    typedef struct {
        logic [XLEN-1:0] a;
        logic            a_we;
        logic [XLEN-1:0] b;
        logic            b_we;
        logic            dst;
        string           tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       op_sel = 2'b11;
    logic [XLEN-1:0]  src_a = '0;
    logic [XLEN-1:0]  src_b = '0;
    logic [IMM_W-1:0] imm = '0;
    logic [XLEN-1:0]  res_a;
    logic             res_a_we;
    logic [XLEN-1:0]  res_b;
    logic             res_b_we;
    logic             dst_is_srcb;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bmx_exec #(.XLEN(XLEN), .IMM_W(IMM_W)) u_dut (
        .op_sel      (op_sel),
        .src_a       (src_a),
        .src_b       (src_b),
        .imm         (imm),
        .res_a       (res_a),
        .res_a_we    (res_a_we),
        .res_b       (res_b),
        .res_b_we    (res_b_we),
        .dst_is_srcb (dst_is_srcb)
    );

    function automatic exp_t model(input logic [1:0] op, input logic [XLEN-1:0] a,
                                   input logic [XLEN-1:0] b, input logic [IMM_W-1:0] im,
                                   input string tag);
        exp_t e;
        e.a = '0; e.b = '0; e.a_we = 1'b0; e.b_we = 1'b0; e.dst = 1'b0; e.tag = tag;
        case (op)
            2'b00: begin
                e.a[15:0] = a[15:0];
                e.b[15:0] = a[31:16];
                e.a_we = 1'b1; e.b_we = 1'b1;
            end
            2'b01: begin
                for (int i = 0; i < XLEN; i++) e.a[i] = (a[i] == b[i]);
                e.a_we = 1'b1;
            end
            2'b10: begin
                for (int i = 0; i < XLEN; i++) begin
                    logic m;
                    m = (i < IMM_W) ? im[i] : im[IMM_W-1];
                    e.a[i] = m ? a[i] : b[i];
                end
                e.a_we = 1'b1; e.dst = 1'b1;
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic drive(input logic [1:0] op, input logic [XLEN-1:0] a,
                         input logic [XLEN-1:0] b, input logic [IMM_W-1:0] im,
                         input string tag);
        @(posedge clk);
        op_sel = op; src_a = a; src_b = b; imm = im;
        sb_q.push_back(model(op, a, b, im, tag));
    endtask

    // monitor: samples half a period after the driver
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (res_a !== e.a || res_a_we !== e.a_we || res_b !== e.b ||
                    res_b_we !== e.b_we || dst_is_srcb !== e.dst) begin
                    n_fail++;
                    $display("FAIL %s: got a=%h wa=%b b=%h wb=%b d=%b exp a=%h wa=%b b=%h wb=%b d=%b",
                             e.tag, res_a, res_a_we, res_b, res_b_we, dst_is_srcb,
                             e.a, e.a_we, e.b, e.b_we, e.dst);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-time idle state: invalid code, nothing written (R8)
        drive(2'b11, '0, '0, '0, "R8 idle");
        // split (R1, R2)
        drive(2'b00, 32'hDEAD_BEEF, 32'h1234_5678, 16'hFFFF, "R1 R2 split");
        drive(2'b00, 32'hFFFF_0000, 32'h0, 16'h0, "R2 split hi");
        drive(2'b00, 32'h0000_FFFF, 32'hFFFF_FFFF, 16'h0, "R1 split lo");
        // bit-equal (R3, R9)
        drive(2'b01, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 16'h0, "R3 equal");
        drive(2'b01, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 16'h0, "R3 opposite");
        drive(2'b01, 32'h1234_5678, 32'h1234_0000, 16'h0, "R9 R3 mixed");
        // replace-under-mask (R4, R5, R6)
        drive(2'b10, 32'hFFFF_FFFF, 32'h0, 16'h8000, "R4 negative imm");
        drive(2'b10, 32'hFFFF_FFFF, 32'h0, 16'h7FFF, "R4 positive imm");
        drive(2'b10, 32'hAAAA_AAAA, 32'h5555_5555, 16'h00F0, "R5 mixed mask");
        drive(2'b10, 32'h1111_1111, 32'h2222_2222, 16'h0000, "R5 empty mask");
        drive(2'b10, 32'h1111_1111, 32'h2222_2222, 16'hFFFF, "R6 R5 full mask");
        // invalid with data present (R8, R7)
        drive(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, "R8 invalid");
        for (int k = 0; k < 40; k++) begin
            logic [1:0] op;
            op = 2'(k % 4);
            drive(op, $urandom, $urandom, 16'($urandom), "R7 sweep");
        end
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule